// File: doc/BRIEF.md
# Parking Address-Bus Arbiter with One-Level Pipelining

This block arbitrates the address bus of a split-transaction bus, where each transfer has an address tenure followed by a separate data tenure. Two masters share the bus. The internal master is the parking default. The external master uses a request input and a grant output. When nobody asks for the bus, the grant rests on the internal master. That master can then issue a transfer start with no request at all.

The arbiter opens an address tenure when a transfer start arrives on an idle address bus. It holds the bus-busy indication until the acknowledge has been given. The acknowledge marks the start of the matching data tenure, and it is issued only when the data bus is free or is freed in that cycle. As a result, one further address tenure can be opened and held while an older data tenure is still running, and data tenures start in address order. Requests are re-evaluated at the acknowledge cycle and whenever the address bus is idle. This lets a master withdraw a request it no longer needs without stalling the bus.

Top module: `abus_park_arbiter`

## Requirements
- R1: While reset is asserted and after its release, before the first transfer: int_gnt_o=1, ext_gnt_o=0, abb_o=0, aack_o=0, dbusy_o=0.
- R2: Exactly one of int_gnt_o and ext_gnt_o is high in every cycle.
- R3: With no request pending on an idle bus, the grant parks on the internal master, and a transfer start from it opens a tenure (abb_o=1 the next cycle) without any request.
- R4: If ext_req_i is high while an internal address tenure is open and not being acknowledged, ext_gnt_o is high the next cycle.
- R5: During an open tenure the grant holds until the acknowledge cycle. In the acknowledge cycle the requests are sampled, and with none pending the grant is on the internal master the next cycle.
- R6: In the acknowledge cycle or on an idle bus, the external master wins a tie unless the most recently accepted tenure was external. In that case the internal master wins.
- R7: A request withdrawn before the grant is used (no transfer start) returns the grant to the internal master in the next cycle.
- R8: ts_i is accepted only while abb_o=0. abb_o rises the cycle after acceptance and stays high up to and including the acknowledge cycle, then falls.
- R9: aack_o is a single-cycle pulse. It rises the cycle after an edge at which a tenure is open, no acknowledge is high, and the data bus is free (dbusy_o=0, or ddone_i=1 in that cycle).
- R10: While a data tenure is busy, a pending address tenure gets no acknowledge until ddone_i is seen. The acknowledge then follows in the next cycle.
- R11: dbusy_o rises together with aack_o, and downer_o (1=external, 0=internal) then names the master of the acknowledged tenure. dbusy_o clears the cycle after ddone_i unless a new acknowledge starts.
- R12: ddone_i while dbusy_o=0 and no acknowledge is starting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_req_i | input | 1 | Internal master bus request |
| ext_req_i | input | 1 | External master bus request |
| ts_i | input | 1 | Transfer start from the current grant holder |
| ddone_i | input | 1 | Current data tenure completes this cycle |
| int_gnt_o | output | 1 | Grant to internal master (parking default) |
| ext_gnt_o | output | 1 | Grant to external master |
| abb_o | output | 1 | Address tenure open (address bus busy) |
| aack_o | output | 1 | Address acknowledge, data tenure begins |
| dbusy_o | output | 1 | Data tenure in progress |
| downer_o | output | 1 | Owner of the data tenure, 1 = external |

## Verification
The block has no parameters, so the bench builds the single fixed configuration. It applies every sequence of three consecutive four-bit input vectors (requests, transfer start, data done), starting from whatever state the previous sequence left. This reaches every combination of open tenure, busy data bus, acknowledge cycle and tie at the sampling point. A bench-side cycle model gives the expected outputs, and directed runs pin down parking, early handoff, cancellation and the held-off acknowledge.

// File: rtl/abp_pkg.sv
package abp_pkg;

  typedef enum logic {
    OWN_INT = 1'b0,
    OWN_EXT = 1'b1
  } owner_e;

  // Arbitration at a sampling point: external preferred, except that the
  // internal master is served after an external tenure when both ask.
  function automatic owner_e pick_owner(input logic ext_req,
                                        input logic int_req,
                                        input owner_e last);
    if (ext_req && !(int_req && last == OWN_EXT)) return OWN_EXT;
    return OWN_INT;
  endfunction

  // The data bus can take a new tenure when idle or freed this cycle.
  function automatic logic data_slot_free(input logic dbusy, input logic ddone);
    return !dbusy || ddone;
  endfunction

endpackage

// File: rtl/abp_tenure.sv
module abp_tenure
  import abp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ts_i,
  input  logic   ddone_i,
  input  owner_e gnt_owner_i,
  output logic   abb_o,
  output logic   aack_o,
  output owner_e aown_o,
  output logic   dbusy_o,
  output owner_e down_o
);

  logic   abb_q, aack_q, dbusy_q;
  owner_e aown_q, down_q;

  // named internal events
  logic ts_take;
  logic aack_fire;

  assign ts_take   = ts_i && !abb_q;
  assign aack_fire = abb_q && !aack_q && data_slot_free(dbusy_q, ddone_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abb_q   <= 1'b0;
      aack_q  <= 1'b0;
      dbusy_q <= 1'b0;
      aown_q  <= OWN_INT;
      down_q  <= OWN_INT;
    end else begin
      aack_q <= aack_fire;
      if (aack_q) begin
        abb_q <= 1'b0;
      end else if (ts_take) begin
        abb_q  <= 1'b1;
        aown_q <= gnt_owner_i;
      end
      if (aack_fire) begin
        dbusy_q <= 1'b1;
        down_q  <= aown_q;
      end else if (ddone_i) begin
        dbusy_q <= 1'b0;
      end
    end
  end

  assign abb_o   = abb_q;
  assign aack_o  = aack_q;
  assign aown_o  = aown_q;
  assign dbusy_o = dbusy_q;
  assign down_o  = down_q;

  // R9
  aack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aack_q |=> !aack_q);

  // R8
  abb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abb_q && !aack_q) |=> abb_q);

  // R8
  abb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aack_q |=> !abb_q);

  // R10
  aack_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(aack_q) && $past(dbusy_q)) |-> $past(ddone_i));

  // R11
  data_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aack_q |-> (dbusy_q && down_q == aown_q));

  // R12
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbusy_q && !aack_fire) |=> !dbusy_q);

endmodule

// File: rtl/abp_grant.sv
module abp_grant
  import abp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ext_req_i,
  input  logic   int_req_i,
  input  logic   abb_i,
  input  logic   aack_i,
  input  owner_e aown_i,
  output logic   int_gnt_o,
  output logic   ext_gnt_o,
  output owner_e owner_o
);

  logic int_gnt_q, ext_gnt_q;

  // named internal events
  logic hold_phase;   // tenure open, not at the sampling point
  logic early_hand;   // external request during an internal tenure
  logic ext_nxt;

  assign hold_phase = abb_i && !aack_i;
  assign early_hand = ext_req_i && aown_i == OWN_INT;

  always_comb begin
    if (hold_phase) ext_nxt = ext_gnt_q || early_hand;
    else            ext_nxt = (pick_owner(ext_req_i, int_req_i, aown_i) == OWN_EXT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_gnt_q <= 1'b1;
      ext_gnt_q <= 1'b0;
    end else begin
      int_gnt_q <= !ext_nxt;
      ext_gnt_q <= ext_nxt;
    end
  end

  assign int_gnt_o = int_gnt_q;
  assign ext_gnt_o = ext_gnt_q;
  assign owner_o   = ext_gnt_q ? OWN_EXT : OWN_INT;

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({int_gnt_q, ext_gnt_q}));

  // R4
  early_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abb_i && !aack_i && aown_i == OWN_INT && ext_req_i) |=> ext_gnt_q);

  // R5
  park_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aack_i && !ext_req_i) |=> int_gnt_q);

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abb_i && !aack_i && ext_gnt_q) |=> ext_gnt_q);

endmodule

// File: rtl/abus_park_arbiter.sv
module abus_park_arbiter
  import abp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic int_req_i,
  input  logic ext_req_i,
  input  logic ts_i,
  input  logic ddone_i,
  output logic int_gnt_o,
  output logic ext_gnt_o,
  output logic abb_o,
  output logic aack_o,
  output logic dbusy_o,
  output logic downer_o
);

  owner_e gnt_owner;
  owner_e aown;
  owner_e down;
  logic   abb, aack;

  abp_tenure u_tenure (
    .clk        (clk),
    .rst_n      (rst_n),
    .ts_i       (ts_i),
    .ddone_i    (ddone_i),
    .gnt_owner_i(gnt_owner),
    .abb_o      (abb),
    .aack_o     (aack),
    .aown_o     (aown),
    .dbusy_o    (dbusy_o),
    .down_o     (down)
  );

  abp_grant u_grant (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_req_i(ext_req_i),
    .int_req_i(int_req_i),
    .abb_i    (abb),
    .aack_i   (aack),
    .aown_i   (aown),
    .int_gnt_o(int_gnt_o),
    .ext_gnt_o(ext_gnt_o),
    .owner_o  (gnt_owner)
  );

  assign abb_o    = abb;
  assign aack_o   = aack;
  assign downer_o = (down == OWN_EXT);

  // R7
  cancel_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!abb && !ext_req_i) |=> int_gnt_o);

endmodule

// File: tb/abus_park_arbiter_test.sv
module abus_park_arbiter_test;

  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic int_req, ext_req, ts, ddone;
  logic int_gnt, ext_gnt, abb, aack, dbusy, downer;

  int nchk = 0;
  int nerr = 0;

  // bench model state
  logic m_gext, m_abb, m_aown, m_aack, m_dbusy, m_down;

  always #(PERIOD/2) clk = ~clk;

  abus_park_arbiter uut (
    .clk(clk), .rst_n(rst_n),
    .int_req_i(int_req), .ext_req_i(ext_req), .ts_i(ts), .ddone_i(ddone),
    .int_gnt_o(int_gnt), .ext_gnt_o(ext_gnt), .abb_o(abb), .aack_o(aack),
    .dbusy_o(dbusy), .downer_o(downer)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_gext = 0; m_abb = 0; m_aown = 0; m_aack = 0; m_dbusy = 0; m_down = 0;
  endtask

  // expected next state from the requirements, given current inputs
  task automatic model_step();
    logic fire, open_hold, n_gext;
    open_hold = m_abb && !m_aack;
    fire = open_hold && (!m_dbusy || ddone);
    if (open_hold) n_gext = m_gext | (ext_req & ~m_aown);
    else if (ext_req && int_req && m_aown) n_gext = 1'b0;
    else n_gext = ext_req;
    if (m_abb && m_aack) m_abb = 1'b0;
    else if (!m_abb && ts) begin m_abb = 1'b1; m_aown = m_gext; end
    if (fire) begin m_dbusy = 1'b1; m_down = m_aown; end
    else if (ddone) m_dbusy = 1'b0;
    m_aack = fire;
    m_gext = n_gext;
  endtask

  task automatic compare_all();
    chk("R2 one grant", int_gnt ^ ext_gnt, 1'b1);
    chk("R6 ext grant", ext_gnt, m_gext);
    chk("R6 int grant", int_gnt, !m_gext);
    chk("R8 abb", abb, m_abb);
    chk("R9 aack", aack, m_aack);
    chk("R11 dbusy", dbusy, m_dbusy);
    chk("R11 downer", downer, m_down);
  endtask

  // one cycle: drive at negedge, edge, check at next negedge
  task automatic cyc(input logic e, input logic i, input logic t, input logic d);
    ext_req = e; int_req = i; ts = t; ddone = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 0; int_req = 0; ext_req = 0; ts = 0; ddone = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 int_gnt", int_gnt, 1'b1);
    chk("R1 ext_gnt", ext_gnt, 1'b0);
    chk("R1 abb", abb, 1'b0);
    chk("R1 aack", aack, 1'b0);
    chk("R1 dbusy", dbusy, 1'b0);
    rst_n = 1;

    // R3 parking, start without request
    cyc(0, 0, 0, 0); chk("R3 parked", int_gnt, 1'b1);
    cyc(0, 0, 1, 0); chk("R3 tenure opened", abb, 1'b1);
    // R4 early handoff during internal tenure
    cyc(1, 0, 0, 0); chk("R4 ext grant", ext_gnt, 1'b1); chk("R9 aack", aack, 1'b1);
    cyc(1, 0, 0, 0); chk("R8 abb falls", abb, 1'b0); chk("R11 dbusy", dbusy, 1'b1);
    // R7 cancel before use
    cyc(0, 0, 0, 0); chk("R7 back to internal", int_gnt, 1'b1);
    // R10 pipelined tenure held off by busy data bus
    cyc(0, 0, 1, 0); chk("R10 second tenure open", abb, 1'b1);
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0, 0); chk("R10 aack held", aack, 1'b0);
    end
    cyc(0, 0, 0, 1); chk("R10 aack after done", aack, 1'b1); chk("R10 dbusy", dbusy, 1'b1);
    cyc(0, 0, 0, 0); chk("R8 abb falls", abb, 1'b0);
    cyc(0, 0, 0, 1); chk("R11 dbusy clears", dbusy, 1'b0);
    // R12 stray done
    cyc(0, 0, 0, 1); chk("R12 dbusy stays low", dbusy, 1'b0); chk("R12 no aack", aack, 1'b0);
    // R6 tie handling
    cyc(1, 1, 0, 0); chk("R6 tie to ext", ext_gnt, 1'b1);
    cyc(1, 1, 1, 0); chk("R8 ext tenure", abb, 1'b1);
    cyc(1, 1, 0, 0); chk("R11 owner ext", downer, 1'b1);
    cyc(1, 1, 0, 0); chk("R6 tie after ext to int", int_gnt, 1'b1);
    cyc(0, 0, 0, 1);
    // R5 grant held during tenure, parks after acknowledge
    cyc(1, 0, 0, 0);
    cyc(1, 0, 1, 0);
    cyc(0, 0, 0, 0); chk("R5 grant held", ext_gnt, 1'b1);
    cyc(0, 0, 0, 0); chk("R5 parks at aack", int_gnt, 1'b1);

    // exhaustive three-vector sequences
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 16; c++) begin
          cyc(a[0], a[1], a[2], a[3]);
          cyc(b[0], b[1], b[2], b[3]);
          cyc(c[0], c[1], c[2], c[3]);
        end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule